// File: doc/BRIEF.md
# Split-Transaction Read Request Buffer

This block sits between up to four processors on a shared bus and four memory modules. A processor posts a read by presenting an address and its own identifier for a single cycle. The block stores the request right away, so the bus is free again after the address phase. Later, the block serves the request in one of two ways. If a posted write that has not yet reached memory holds the address, the block returns that data. Otherwise it reads the data from the memory module selected by the address.

Each finished result waits in the buffer, tagged with the identifier of the processor that asked for it. The block announces the oldest finished result on a ready output that carries that identifier. The processor picks up the data word and acknowledges it, and the acknowledge frees the slot. Requests are served in the order they arrived, and results are delivered in the same order. When every slot is taken, a processor that presents a new request is told to wait.

Top module: `split_read_buf`

## Requirements
- R1: A request is stored only in a cycle where `req_sel`, `req_rd` and `req_type` are all 1 and `req_wr` is 0. Any other combination is ignored: it causes no memory strobe and no ready indication.
- R2: A stored request keeps its 32-bit address and its 2-bit processor identifier (0 to 3). When its result is ready, `rdy_id` shows that identifier and `rdy_data` shows the data.
- R3: The buffer holds at most `DEPTH` requests, whether served or not. While it is full, `req_wait` is 1 in any cycle that carries a qualifying request, and that request is not stored.
- R4: Before memory is read, the address of the oldest unserved request is offered on `wb_look_addr` with `wb_look_en` set to 1. If `wb_hit` answers 1 in that cycle, `wb_data` becomes the result and no memory strobe is issued for that request.
- R5: On a lookup miss, the two most significant address bits N select memory module N. During the strobe, `mem_sel` is one-hot with bit N set and `mem_addr` carries the full request address.
- R6: A memory read keeps `mem_rd` at 1 for exactly `STROBE_CYC` consecutive cycles. `mem_data` is taken as the result in the last of those cycles.
- R7: While the `mem_busy` bit of the selected module is 1, the read does not start. It starts once that bit is 0.
- R8: Results are offered in the order the requests arrived. `rdy_valid` is 1 whenever at least one served result has not yet been collected.
- R9: Setting `col_ack` to 1 while `rdy_valid` is 1 collects the offered entry and frees its slot. A full buffer can then accept a new request.
- R10: After reset, `rdy_valid`, `mem_rd` and `req_wait` are 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_sel | input | 1 | Block selected by the bus |
| req_rd | input | 1 | Read strobe from the processor |
| req_wr | input | 1 | Write strobe from the processor (must be 0 for a read request) |
| req_type | input | 1 | Transaction-type valid |
| req_addr | input | AW | Requested address |
| req_id | input | 2 | Identifier of the requesting processor |
| req_wait | output | 1 | Buffer full: the requester must hold |
| wb_look_en | output | 1 | Lookup into the posted-write store is active |
| wb_look_addr | output | AW | Address being looked up |
| wb_hit | input | 1 | The posted-write store holds the looked-up address |
| wb_data | input | DW | Data from the posted-write store on a hit |
| mem_rd | output | 1 | Memory read strobe |
| mem_sel | output | 4 | One-hot memory module select |
| mem_addr | output | AW | Memory address |
| mem_busy | input | 4 | Busy flag for each memory module |
| mem_data | input | DW | Read data from the memory |
| rdy_valid | output | 1 | A served result is waiting to be collected |
| rdy_id | output | 2 | Identifier of the processor that owns the offered result |
| rdy_data | output | DW | Offered result data |
| col_ack | input | 1 | Processor collects the offered result |

## Verification
The bench builds the block with `DEPTH` = 4 and `STROBE_CYC` = 3. With four slots, it can fill the buffer with a handful of requests by holding every memory module busy. That setup exercises the wait response, freeing a slot by collection, and in-order delivery of a full batch. The short strobe keeps each miss brief, yet it still spans several cycles, so the bench can count the strobe length and check the module select on every cycle of it. A bench model of the posted-write store answers for one address, which puts a hit and a near miss side by side.

// File: rtl/split_read_buf.sv
module split_read_buf #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DEPTH      = 30,
  parameter int STROBE_CYC = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_sel,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic          req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_id,
  output logic          req_wait,
  output logic          wb_look_en,
  output logic [AW-1:0] wb_look_addr,
  input  logic          wb_hit,
  input  logic [DW-1:0] wb_data,
  output logic          mem_rd,
  output logic [3:0]    mem_sel,
  output logic [AW-1:0] mem_addr,
  input  logic [3:0]    mem_busy,
  input  logic [DW-1:0] mem_data,
  output logic          rdy_valid,
  output logic [1:0]    rdy_id,
  output logic [DW-1:0] rdy_data,
  input  logic          col_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

  typedef enum logic {S_IDLE, S_STRB} st_t;

  logic [AW-1:0] a_mem [DEPTH];
  logic [1:0]    id_mem [DEPTH];
  logic [DW-1:0] d_mem [DEPTH];

  logic [PW-1:0] wp, pp, rp;
  logic [CW-1:0] cnt, ndone;
  logic [SW-1:0] scnt;
  st_t           st;

  logic          req_q, full, acc, take, pend, hit_take, start, fin, done;
  logic [AW-1:0] cur_addr;
  logic [1:0]    mod;
  logic [DW-1:0] res;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign req_q    = req_sel & req_rd & req_type & ~req_wr;
  assign full     = (cnt == CW'(DEPTH));
  assign req_wait = req_q & full;
  assign acc      = req_q & ~full;

  assign rdy_valid = (ndone != '0);
  assign rdy_id    = id_mem[rp];
  assign rdy_data  = d_mem[rp];
  assign take      = col_ack & rdy_valid;

  assign pend         = (cnt != ndone);
  assign cur_addr     = a_mem[pp];
  assign mod          = cur_addr[AW-1 -: 2];
  assign wb_look_en   = pend && (st == S_IDLE);
  assign wb_look_addr = cur_addr;
  assign hit_take     = wb_look_en & wb_hit;
  assign start        = wb_look_en & ~wb_hit & ~mem_busy[mod];
  assign fin          = (st == S_STRB) && (scnt == SW'(STROBE_CYC - 1));
  assign done         = hit_take | fin;
  assign res          = hit_take ? wb_data : mem_data;

  assign mem_rd   = (st == S_STRB);
  assign mem_addr = cur_addr;
  assign mem_sel  = mem_rd ? (4'b0001 << mod) : 4'b0000;

  always_ff @(posedge clk) begin
    if (acc) begin
      a_mem[wp]  <= req_addr;
      id_mem[wp] <= req_id;
    end
    if (done) d_mem[pp] <= res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      pp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ndone <= '0;
      scnt  <= '0;
      st    <= S_IDLE;
    end else begin
      if (acc)  wp <= nxt(wp);
      if (done) pp <= nxt(pp);
      if (take) rp <= nxt(rp);
      cnt   <= cnt + CW'(acc) - CW'(take);
      ndone <= ndone + CW'(done) - CW'(take);
      case (st)
        S_IDLE: if (start) begin
          st   <= S_STRB;
          scnt <= '0;
        end
        S_STRB: if (fin) st <= S_IDLE;
                else     scnt <= scnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH) && ndone <= cnt);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (req_wait && !take) |=> cnt == $past(cnt));

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> $countones(mem_sel) == 1);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> ($past(mem_busy) & mem_sel) == 4'b0000);

  p_hit_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_look_en && wb_hit) |=> !mem_rd);
endmodule

// File: tb/split_read_buf_tb.sv
module split_read_buf_tb_top;
  localparam int DEPTH = 4;
  localparam int SC    = 3;
  localparam logic [31:0] WB_ADDR = 32'h8000_0040;
  localparam logic [31:0] WB_DATA = 32'hFEED_0001;
  localparam int NV = 6;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0100, 32'h4000_0204, 32'h8000_0040,
                                         32'hC000_0FFC, 32'h8000_0044, 32'h0000_0000};
  localparam logic [1:0]  V_ID   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};

  logic clk = 0, rst = 1;
  logic req_sel = 0, req_rd = 0, req_wr = 0, req_type = 0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_id = '0;
  logic req_wait, wb_look_en, wb_hit, mem_rd, rdy_valid, col_ack = 0;
  logic [31:0] wb_look_addr, wb_data, mem_addr, mem_data, rdy_data;
  logic [3:0]  mem_sel, mem_busy = '0;
  logic [1:0]  rdy_id;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign wb_hit   = wb_look_en && (wb_look_addr == WB_ADDR);
  assign wb_data  = WB_DATA;
  assign mem_data = mem_rd ? ~mem_addr : 32'h0;

  split_read_buf #(.AW(32), .DW(32), .DEPTH(DEPTH), .STROBE_CYC(SC)) dut_i (
    .clk(clk), .rst(rst), .req_sel(req_sel), .req_rd(req_rd), .req_wr(req_wr),
    .req_type(req_type), .req_addr(req_addr), .req_id(req_id), .req_wait(req_wait),
    .wb_look_en(wb_look_en), .wb_look_addr(wb_look_addr), .wb_hit(wb_hit),
    .wb_data(wb_data), .mem_rd(mem_rd), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_busy(mem_busy), .mem_data(mem_data), .rdy_valid(rdy_valid),
    .rdy_id(rdy_id), .rdy_data(rdy_data), .col_ack(col_ack));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input bit r, input bit t, input bit w,
                       input logic [31:0] a, input logic [1:0] i);
    @(negedge clk);
    req_sel = s; req_rd = r; req_type = t; req_wr = w; req_addr = a; req_id = i;
    @(negedge clk);
    req_sel = 0; req_rd = 0; req_type = 0; req_wr = 0;
  endtask

  task automatic take(input logic [1:0] eid, input logic [31:0] edata, input int estb,
                      input logic [1:0] emod, input string tag);
    int n = 0;
    int s = 0;
    bit sel_ok = 1;
    while (!rdy_valid && n < 200) begin
      @(negedge clk);
      n++;
      if (mem_rd) begin
        s++;
        if (mem_sel != (4'b0001 << emod)) sel_ok = 0;
      end
    end
    chk(rdy_valid, {tag, " R8 ready"}, 32'(rdy_valid), 32'd1);
    chk(rdy_id == eid, {tag, " R2 id"}, 32'(rdy_id), 32'(eid));
    chk(rdy_data == edata, {tag, " R2 data"}, rdy_data, edata);
    if (estb >= 0) begin
      chk(s == estb, {tag, " R6/R4 strobe cycles"}, 32'(s), 32'(estb));
      chk(sel_ok, {tag, " R5 module select"}, 32'(sel_ok), 32'd1);
    end
    col_ack = 1;
    @(negedge clk);
    col_ack = 0;
  endtask

  function automatic logic [31:0] expd(input logic [31:0] a);
    return (a == WB_ADDR) ? WB_DATA : ~a;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdy_valid && !mem_rd && !req_wait, "R10 reset outputs",
        {29'd0, rdy_valid, mem_rd, req_wait}, 32'd0);
    rst = 0;

    for (int k = 0; k < NV; k++) begin
      drive(1, 1, 1, 0, V_ADDR[k], V_ID[k]);
      take(V_ID[k], expd(V_ADDR[k]), (V_ADDR[k] == WB_ADDR) ? 0 : SC,
           V_ADDR[k][31:30], $sformatf("vec%0d", k));
    end

    // R1: non-qualifying combinations ignored
    drive(1, 1, 1, 1, 32'h4000_0010, 2'd1);
    drive(0, 1, 1, 0, 32'h4000_0020, 2'd1);
    drive(1, 1, 0, 0, 32'h4000_0030, 2'd1);
    drive(1, 0, 1, 0, 32'h4000_0040, 2'd1);
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (mem_rd || rdy_valid) seen++;
      end
      chk(seen == 0, "R1 ignored requests", 32'(seen), 32'd0);
    end

    // R7: busy module delays the read
    mem_busy = 4'b0100;
    drive(1, 1, 1, 0, 32'h8000_1000, 2'd3);
    begin
      int seen = 0;
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        if (mem_rd || rdy_valid) seen++;
      end
      chk(seen == 0, "R7 held while busy", 32'(seen), 32'd0);
    end
    mem_busy = 4'b0000;
    take(2'd3, ~32'h8000_1000, SC, 2'd2, "busy_rel R7");

    // R3/R8/R9: fill, wait, free one slot, order
    mem_busy = 4'b1111;
    for (int k = 0; k < DEPTH; k++)
      drive(1, 1, 1, 0, {2'(k), 30'h100 + 30'(k)}, 2'(k));
    @(negedge clk);
    req_sel = 1; req_rd = 1; req_type = 1; req_addr = 32'h0000_0BAD; req_id = 2'd0;
    #1;
    chk(req_wait, "R3 wait when full", 32'(req_wait), 32'd1);
    @(negedge clk);
    req_sel = 0; req_rd = 0; req_type = 0;
    mem_busy = 4'b0000;
    repeat (40) @(negedge clk);
    req_sel = 1; req_rd = 1; req_type = 1;
    #1;
    chk(req_wait, "R3 wait when full of served entries", 32'(req_wait), 32'd1);
    @(negedge clk);
    req_sel = 0; req_rd = 0; req_type = 0;
    take(2'd0, ~32'h0000_0100, -1, 2'd0, "fifo0 R8");
    @(negedge clk);
    req_sel = 1; req_rd = 1; req_type = 1; req_addr = 32'h4000_0777; req_id = 2'd2;
    #1;
    chk(!req_wait, "R9 slot freed after collect", 32'(req_wait), 32'd0);
    @(negedge clk);
    req_sel = 0; req_rd = 0; req_type = 0;
    for (int k = 1; k < DEPTH; k++)
      take(2'(k), ~{2'(k), 30'h100 + 30'(k)}, -1, 2'(k), $sformatf("fifo%0d R8", k));
    take(2'd2, ~32'h4000_0777, -1, 2'd1, "after_free R9");
    repeat (10) @(negedge clk);
    chk(!rdy_valid, "R3 rejected request not stored", 32'(rdy_valid), 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule